// File: doc/BRIEF.md
# Multi-Source Measurement Data FIFO

This block buffers results from a measurement front end until software or a DMA engine collects them. A 3-bit selector in a small configuration register picks which processing stage writes into the buffer. The choices are filtered converter samples, complex transform results, a secondary filter stream, a variance result or a mean result. Each entry is 18 bits wide. A complex transform result fills two entries in the same clock cycle. The real part is stored first and is read out first.

Software takes entries through a 32-bit read word. Bits [17:0] hold the oldest entry, bits [24:18] are always zero, and bits [31:25] hold a 7-bit single-error-correct, double-error-detect code computed over bits [24:0]. When the buffer is empty, the read word is all zero and a read strobe changes nothing. A configuration bit holds the whole buffer in reset. A second bit gates a DMA request that is raised while data is waiting. The status outputs give full, empty, fill level and a sticky overflow flag.

Top module: `meas_fifo`

## Requirements
- R1: The configuration word places the source code in bits [15:13], the DMA-request enable in bit 12 and the buffer enable in bit 11. A write with `cfg_wr_en` updates these fields at the next edge. `cfg_rdata` returns them in the same positions with every other bit zero, and all three fields reset to 0.
- R2: Source codes 000, 001, 110 and 111 select the converter stream (`cnv_*`). Code 011 selects the secondary filter stream (`flt2_*`), 100 selects the variance result (`var_*`) and 101 selects the mean result (`mean_*`). Valid strobes from unselected stages have no effect.
- R3: Source code 010 selects the transform stream. A valid transform result writes two entries in one cycle, `xfm_re` and then `xfm_im`, and both are read out in that order. If fewer than two slots are free, both entries are dropped.
- R4: From the cycle after the enable bit is seen at 0, and for as long as it stays 0, the buffer is empty, the level is 0 and the overflow flag is clear. Writes and reads have no effect while the buffer is disabled.
- R5: The read word carries the oldest entry in bits [17:0] and zeros in bits [24:18].
- R6: Read-word bits [30:25] are Hamming parity bits p0..p5 and bit 31 is the overall parity. The 25 protected bits d0..d24 occupy, in order, the codeword positions 1..31 that are not powers of two. Bit pi is the XOR of the data at positions whose index has bit i set. The overall parity bit is the XOR of all 25 data bits and p0..p5.
- R7: While the buffer is empty, `rd_data` is 0x00000000 and `rd_en` does not move the read pointer.
- R8: `dma_req` is high exactly when the DMA enable bit and the buffer enable bit are both 1 and the buffer holds at least one entry.
- R9: `st_level` gives the number of stored entries. `st_empty` is high when the level is 0, and `st_full` is high when the level equals DEPTH.
- R10: A write that does not fit is dropped and sets `st_ovf`. The flag stays set until `ovf_clr` is pulsed or the buffer is disabled. If a drop and `ovf_clr` happen in the same cycle, the flag ends up set.
- R11: Changing the source code while the buffer is enabled keeps the stored entries and their order.
- R12: A read and a write in the same cycle both take effect, so a one-entry write leaves the level unchanged. Whether the write fits is judged on the level before that read.
- R13: Entries leave in the order they were written. `rd_data` shows the oldest entry, and `rd_en` removes it at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| cnv_vld | input | 1 | Converter sample valid |
| cnv_data | input | 18 | Converter sample |
| xfm_vld | input | 1 | Transform result valid |
| xfm_re | input | 18 | Transform real part |
| xfm_im | input | 18 | Transform imaginary part |
| flt2_vld | input | 1 | Secondary filter valid |
| flt2_data | input | 18 | Secondary filter sample |
| var_vld | input | 1 | Variance result valid |
| var_data | input | 18 | Variance result |
| mean_vld | input | 1 | Mean result valid |
| mean_data | input | 18 | Mean result |
| rd_en | input | 1 | Read strobe, removes the oldest entry |
| rd_data | output | 32 | Packed read word with ECC |
| ovf_clr | input | 1 | Clears the overflow flag |
| dma_req | output | 1 | DMA request |
| st_full | output | 1 | Buffer full |
| st_empty | output | 1 | Buffer empty |
| st_level | output | $clog2(DEPTH+1) | Fill level |
| st_ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions check several properties on every cycle. An empty buffer reads as zero, and bits [24:18] of the read word stay zero. The DMA request never rises without data or without its enable. A disabled buffer stays empty with no overflow. The overflow flag stays set until it is cleared, and the level never exceeds DEPTH or grows by more than two per cycle. Other behaviour only shows in the bench's scenarios against its queue model. These are the decoding of all eight source codes, the real-then-imaginary order and the all-or-nothing drop of transform pairs, and the ECC values. The scenarios also cover the set-wins rule for overflow, the level holding steady under simultaneous read and write, and entries surviving a change of source.

// File: rtl/mf_pkg.sv
package mf_pkg;

  localparam int unsigned DW     = 18;
  localparam int unsigned PROT_W = 25;
  localparam int unsigned ECC_W  = 7;

  localparam int unsigned CFG_SRC_LSB = 13;
  localparam int unsigned CFG_DMA_BIT = 12;
  localparam int unsigned CFG_EN_BIT  = 11;

  typedef enum logic [2:0] {
    SRC_CNV_A = 3'b000,
    SRC_CNV_B = 3'b001,
    SRC_XFM   = 3'b010,
    SRC_FLT2  = 3'b011,
    SRC_VAR   = 3'b100,
    SRC_MEAN  = 3'b101,
    SRC_CNV_C = 3'b110,
    SRC_CNV_D = 3'b111
  } src_e;

  typedef struct packed {
    src_e src;
    logic dma_en;
    logic fifo_en;
  } cfg_t;

  // SECDED over the protected bits: data fills non-power-of-two codeword
  // positions 1..31 in order; parity bit i covers positions with bit i set.
  function automatic logic [ECC_W-1:0] secded(input logic [PROT_W-1:0] d);
    logic [5:0] p;
    logic       ovr;
    int         k;
    p = '0;
    k = 0;
    for (int pos = 1; pos < 32; pos++) begin
      if (((pos & (pos - 1)) != 0) && (k < int'(PROT_W))) begin
        for (int b = 0; b < 6; b++) begin
          if (((pos >> b) & 1) == 1) p[3'(b)] = p[3'(b)] ^ d[5'(k)];
        end
        k++;
      end
    end
    ovr = (^d) ^ (^p);
    return {ovr, p};
  endfunction

endpackage

// File: rtl/mf_src_mux.sv
module mf_src_mux
  import mf_pkg::*;
(
  input  src_e          src,
  input  logic          cnv_vld,
  input  logic [DW-1:0] cnv_data,
  input  logic          xfm_vld,
  input  logic [DW-1:0] xfm_re,
  input  logic [DW-1:0] xfm_im,
  input  logic          flt2_vld,
  input  logic [DW-1:0] flt2_data,
  input  logic          var_vld,
  input  logic [DW-1:0] var_data,
  input  logic          mean_vld,
  input  logic [DW-1:0] mean_data,
  output logic [1:0]    wr_n,
  output logic [DW-1:0] wd0,
  output logic [DW-1:0] wd1
);

  always_comb begin
    wr_n = 2'd0;
    wd0  = cnv_data;
    wd1  = xfm_im;
    case (src)
      SRC_XFM: begin
        wr_n = xfm_vld ? 2'd2 : 2'd0;
        wd0  = xfm_re;
      end
      SRC_FLT2: begin
        wr_n = {1'b0, flt2_vld};
        wd0  = flt2_data;
      end
      SRC_VAR: begin
        wr_n = {1'b0, var_vld};
        wd0  = var_data;
      end
      SRC_MEAN: begin
        wr_n = {1'b0, mean_vld};
        wd0  = mean_data;
      end
      default: begin
        wr_n = {1'b0, cnv_vld};
        wd0  = cnv_data;
      end
    endcase
  end

endmodule

// File: rtl/mf_store.sv
module mf_store
  import mf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    wr_n,
  input  logic [DW-1:0] wd0,
  input  logic [DW-1:0] wd1,
  input  logic          rd_req,
  input  logic          ovf_clr,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovf
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] LVL_MAX  = LW'(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d, wp1;
  logic [LW-1:0] lvl_q, lvl_d, free_slots;
  logic          ovf_q, ovf_d;
  logic          accept, drop, pop, we0, we1;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  // next-state logic
  always_comb begin
    free_slots = LVL_MAX - lvl_q;
    wp1        = ptr_inc(wp_q);
    accept     = !clr && (wr_n != 2'd0) && (LW'(wr_n) <= free_slots);
    drop       = !clr && (wr_n != 2'd0) && !accept;
    pop        = !clr && rd_req && (lvl_q != '0);
    we0        = accept;
    we1        = accept && (wr_n == 2'd2);

    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    ovf_d = ovf_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (accept) wp_d = (wr_n == 2'd2) ? ptr_inc(wp1) : wp1;
      if (pop)    rp_d = ptr_inc(rp_q);
      lvl_d = lvl_q + (accept ? LW'(wr_n) : '0) - (pop ? LW'(1) : '0);
      if (ovf_clr) ovf_d = 1'b0;
      if (drop)    ovf_d = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
      ovf_q <= ovf_d;
    end
  end

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (we0) mem[wp_q] <= wd0;
    if (we1) mem[wp1]  <= wd1;
  end

  assign head  = mem[rp_q];
  assign level = lvl_q;
  assign empty = (lvl_q == '0);
  assign full  = (lvl_q == LVL_MAX);
  assign ovf   = ovf_q;

endmodule

// File: rtl/mf_pack.sv
module mf_pack
  import mf_pkg::*;
(
  input  logic          vld,
  input  logic [DW-1:0] head,
  output logic [31:0]   word
);

  logic [PROT_W-1:0] low;
  logic [ECC_W-1:0]  ecc;

  always_comb begin
    low  = {{(PROT_W - DW){1'b0}}, head};
    ecc  = secded(low);
    word = vld ? {ecc, low} : 32'h0000_0000;
  end

endmodule

// File: rtl/meas_fifo.sv
module meas_fifo
  import mf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            cnv_vld,
  input  logic [DW-1:0]   cnv_data,
  input  logic            xfm_vld,
  input  logic [DW-1:0]   xfm_re,
  input  logic [DW-1:0]   xfm_im,
  input  logic            flt2_vld,
  input  logic [DW-1:0]   flt2_data,
  input  logic            var_vld,
  input  logic [DW-1:0]   var_data,
  input  logic            mean_vld,
  input  logic [DW-1:0]   mean_data,
  input  logic            rd_en,
  output logic [31:0]     rd_data,
  input  logic            ovf_clr,
  output logic            dma_req,
  output logic            st_full,
  output logic            st_empty,
  output logic [LVLW-1:0] st_level,
  output logic            st_ovf
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // configuration register
  cfg_t cfg_q, cfg_d;
  logic unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata[31:16], cfg_wdata[10:0]};

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr_en) begin
      cfg_d.src     = src_e'(cfg_wdata[CFG_SRC_LSB +: 3]);
      cfg_d.dma_en  = cfg_wdata[CFG_DMA_BIT];
      cfg_d.fifo_en = cfg_wdata[CFG_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) cfg_q <= '{src: SRC_CNV_A, dma_en: 1'b0, fifo_en: 1'b0};
    else          cfg_q <= cfg_d;
  end

  always_comb begin
    cfg_rdata = 32'h0;
    cfg_rdata[CFG_SRC_LSB +: 3] = cfg_q.src;
    cfg_rdata[CFG_DMA_BIT]      = cfg_q.dma_en;
    cfg_rdata[CFG_EN_BIT]       = cfg_q.fifo_en;
  end

  // writer selection
  logic [1:0]    wr_n;
  logic [DW-1:0] wd0, wd1;

  mf_src_mux u_mux (
    .src       (cfg_q.src),
    .cnv_vld   (cnv_vld),
    .cnv_data  (cnv_data),
    .xfm_vld   (xfm_vld),
    .xfm_re    (xfm_re),
    .xfm_im    (xfm_im),
    .flt2_vld  (flt2_vld),
    .flt2_data (flt2_data),
    .var_vld   (var_vld),
    .var_data  (var_data),
    .mean_vld  (mean_vld),
    .mean_data (mean_data),
    .wr_n      (wr_n),
    .wd0       (wd0),
    .wd1       (wd1)
  );

  // storage and pointers
  logic [DW-1:0] head;

  mf_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr     (!cfg_q.fifo_en),
    .wr_n    (wr_n),
    .wd0     (wd0),
    .wd1     (wd1),
    .rd_req  (rd_en),
    .ovf_clr (ovf_clr),
    .head    (head),
    .level   (st_level),
    .full    (st_full),
    .empty   (st_empty),
    .ovf     (st_ovf)
  );

  // read word packing
  mf_pack u_pack (
    .vld  (!st_empty),
    .head (head),
    .word (rd_data)
  );

  assign dma_req = cfg_q.dma_en && cfg_q.fifo_en && !st_empty;

endmodule

// File: rtl/mf_chk.sv
module mf_chk #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   cfg_rdata,
  input logic [31:0]   rd_data,
  input logic          ovf_clr,
  input logic          dma_req,
  input logic          st_full,
  input logic          st_empty,
  input logic [LW-1:0] st_level,
  input logic          st_ovf
);

  a_r7_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty |-> (rd_data == 32'h0));

  a_r5_gap_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[24:18] == 7'h00);

  a_r8_dma_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[12] |-> !dma_req);

  a_r8_dma_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !st_empty);

  a_r4_disabled_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[11] && $past(!cfg_rdata[11])) |-> (st_empty && !st_ovf));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovf && !ovf_clr && cfg_rdata[11]) |=> st_ovf);

  a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_level <= LW'(DEPTH)) && !(st_full && st_empty));

  a_r12_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, st_level} <= {1'b0, $past(st_level)} + (LW+1)'(2)));

endmodule

bind meas_fifo mf_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/meas_fifo_tb.sv
module meas_fifo_tb;

  localparam int DEPTH = 4;
  localparam int LW    = $clog2(DEPTH + 1);

  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        cnv_vld, xfm_vld, flt2_vld, var_vld, mean_vld;
  logic [17:0] cnv_data, xfm_re, xfm_im, flt2_data, var_data, mean_data;
  logic        rd_en;
  logic [31:0] rd_data;
  logic        ovf_clr;
  logic        dma_req, st_full, st_empty, st_ovf;
  logic [LW-1:0] st_level;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  meas_fifo #(.DEPTH(DEPTH)) u_dut (.*);

  int total = 0;
  int bad   = 0;

  logic [17:0] q[$];
  logic        m_ovf = 1'b0;
  logic [2:0]  m_src = 3'b000;
  logic        m_dma = 1'b0;
  logic        m_en  = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_ecc(input logic [24:0] d);
    logic [31:0] cw;
    logic [6:0]  e;
    logic        par;
    int          k;
    cw = '0;
    e  = '0;
    k  = 0;
    for (int pos = 3; pos < 32; pos++) begin
      if (!$onehot(pos) && k < 25) begin
        cw[5'(pos)] = d[5'(k)];
        k++;
      end
    end
    for (int i = 0; i < 6; i++) begin
      par = 1'b0;
      for (int pos = 1; pos < 32; pos++)
        if ((pos & (1 << i)) != 0) par = par ^ cw[5'(pos)];
      e[3'(i)] = par;
    end
    e[6] = (^d) ^ (^e[5:0]);
    return e;
  endfunction

  function automatic logic [31:0] ref_word(input logic [17:0] v);
    logic [24:0] lo;
    lo = {7'b0, v};
    return {ref_ecc(lo), lo};
  endfunction

  // one clock: check outputs against the model, advance the model, release strobes
  task automatic cyc();
    int          n, sz;
    logic [17:0] a, b;
    #1;
    sz = q.size();
    if (sz > 0) begin
      chk("R13", "rd_data", rd_data, ref_word(q[0]));
      chk("R5", "gap bits", 32'(rd_data[24:18]), 32'h0);
      chk("R6", "ecc", 32'(rd_data[31:25]), 32'(ref_ecc({7'b0, q[0]})));
    end else begin
      chk("R7", "empty read word", rd_data, 32'h0);
    end
    chk("R9", "level", 32'(st_level), 32'(sz));
    chk("R9", "empty", 32'(st_empty), 32'(sz == 0));
    chk("R9", "full", 32'(st_full), 32'(sz == DEPTH));
    chk("R8", "dma_req", 32'(dma_req), 32'(m_dma && m_en && sz > 0));
    chk("R10", "ovf", 32'(st_ovf), 32'(m_ovf));
    chk("R1", "cfg_rdata", cfg_rdata, {16'h0, m_src, m_dma, m_en, 11'h0});

    n = 0; a = '0; b = '0;
    case (m_src)
      3'b010: if (xfm_vld)  begin n = 2; a = xfm_re; b = xfm_im; end
      3'b011: if (flt2_vld) begin n = 1; a = flt2_data; end
      3'b100: if (var_vld)  begin n = 1; a = var_data; end
      3'b101: if (mean_vld) begin n = 1; a = mean_data; end
      default: if (cnv_vld) begin n = 1; a = cnv_data; end
    endcase
    if (!m_en) begin
      q.delete();
      m_ovf = 1'b0;
    end else begin
      if (ovf_clr) m_ovf = 1'b0;
      if (n != 0 && n > DEPTH - sz) m_ovf = 1'b1;
      if (rd_en && sz > 0) void'(q.pop_front());
      if (n != 0 && n <= DEPTH - sz) begin
        q.push_back(a);
        if (n == 2) q.push_back(b);
      end
    end
    if (cfg_wr_en) begin
      m_src = cfg_wdata[15:13];
      m_dma = cfg_wdata[12];
      m_en  = cfg_wdata[11];
    end
    @(negedge clk);
    cfg_wr_en = 1'b0; rd_en = 1'b0; ovf_clr = 1'b0;
    cnv_vld = 1'b0; xfm_vld = 1'b0; flt2_vld = 1'b0; var_vld = 1'b0; mean_vld = 1'b0;
  endtask

  task automatic set_cfg(input logic [2:0] src, input logic dma, input logic en);
    cfg_wr_en = 1'b1;
    cfg_wdata = {16'hA5C3, src, dma, en, 11'h5AB};
    cyc();
  endtask

  task automatic all_valid(input logic [17:0] base);
    cnv_vld = 1'b1;  cnv_data  = base ^ 18'h00001;
    xfm_vld = 1'b1;  xfm_re    = base ^ 18'h00010; xfm_im = base ^ 18'h00020;
    flt2_vld = 1'b1; flt2_data = base ^ 18'h00100;
    var_vld = 1'b1;  var_data  = base ^ 18'h01000;
    mean_vld = 1'b1; mean_data = base ^ 18'h10000;
  endtask

  task automatic drain();
    while (q.size() > 0) begin
      rd_en = 1'b1;
      cyc();
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wdata = '0; rd_en = 1'b0; ovf_clr = 1'b0;
    cnv_vld = 1'b0; xfm_vld = 1'b0; flt2_vld = 1'b0; var_vld = 1'b0; mean_vld = 1'b0;
    cnv_data = '0; xfm_re = '0; xfm_im = '0; flt2_data = '0; var_data = '0; mean_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state and R4 disabled writes ignored
    chk("R1", "reset cfg", cfg_rdata, 32'h0);
    all_valid(18'h0);
    cyc();
    chk("R4", "disabled write ignored", 32'(st_level), 32'h0);
    rd_en = 1'b1;
    cyc();

    // R2/R3 sweep over every source code
    for (int code = 0; code < 8; code++) begin
      set_cfg(3'(code), 1'b0, 1'b1);
      all_valid(18'(code) << 6);
      cyc();
      chk("R2", "entries for code", 32'(st_level), (code == 2) ? 32'd2 : 32'd1);
      if (code == 2)
        chk("R3", "real part first", 32'(rd_data[17:0]), 32'((18'(code) << 6) ^ 18'h00010));
      else if (code == 3)
        chk("R2", "flt2 selected", 32'(rd_data[17:0]), 32'((18'(code) << 6) ^ 18'h00100));
      drain();
    end

    // R7 empty read does not move pointer
    rd_en = 1'b1;
    cyc();
    cnv_vld = 1'b0;
    set_cfg(3'b000, 1'b1, 1'b1);
    cnv_vld = 1'b1; cnv_data = 18'h2AAAA;
    cyc();
    chk("R7", "entry after empty read", 32'(rd_data[17:0]), 32'h2AAAA);
    drain();

    // R6/R13 data pattern sweep: walking ones and edge values
    for (int i = 0; i < 20; i++) begin
      cnv_vld = 1'b1;
      cnv_data = (i < 18) ? (18'h1 << i) : ((i == 18) ? 18'h3FFFF : 18'h0);
      cyc();
      if (q.size() == DEPTH) drain();
    end
    drain();

    // R9/R10 fill to full, overflow, clear, set-wins
    for (int i = 0; i < DEPTH; i++) begin
      cnv_vld = 1'b1; cnv_data = 18'(i + 100);
      cyc();
    end
    chk("R9", "full after fill", 32'(st_full), 32'h1);
    cnv_vld = 1'b1; cnv_data = 18'h3;
    cyc();
    chk("R10", "overflow set", 32'(st_ovf), 32'h1);
    cyc();
    chk("R10", "overflow sticky", 32'(st_ovf), 32'h1);
    ovf_clr = 1'b1;
    cyc();
    chk("R10", "overflow cleared", 32'(st_ovf), 32'h0);
    ovf_clr = 1'b1; cnv_vld = 1'b1;
    cyc();
    chk("R10", "set wins over clear", 32'(st_ovf), 32'h1);
    ovf_clr = 1'b1;
    cyc();

    // R12 read and write at full: write judged before the read
    rd_en = 1'b1; cnv_vld = 1'b1; cnv_data = 18'h77;
    cyc();
    chk("R12", "full write dropped despite read", 32'(st_level), 32'(DEPTH - 1));
    rd_en = 1'b1; cnv_vld = 1'b1; cnv_data = 18'h78;
    cyc();
    chk("R12", "level unchanged", 32'(st_level), 32'(DEPTH - 1));
    ovf_clr = 1'b1;
    cyc();

    // R3 pair with one free slot is dropped whole
    set_cfg(3'b010, 1'b1, 1'b1);
    xfm_vld = 1'b1; xfm_re = 18'h11; xfm_im = 18'h22;
    cyc();
    chk("R3", "pair dropped with one slot", 32'(st_level), 32'(DEPTH - 1));
    chk("R3", "pair drop flags overflow", 32'(st_ovf), 32'h1);
    drain();

    // R11 source change keeps contents
    set_cfg(3'b101, 1'b1, 1'b1);
    mean_vld = 1'b1; mean_data = 18'h1234;
    cyc();
    set_cfg(3'b100, 1'b1, 1'b1);
    var_vld = 1'b1; var_data = 18'h4321;
    cyc();
    chk("R11", "old entry kept", 32'(rd_data[17:0]), 32'h1234);
    chk("R11", "level after switch", 32'(st_level), 32'h2);

    // R8 DMA gating
    set_cfg(3'b100, 1'b0, 1'b1);
    chk("R8", "dma off", 32'(dma_req), 32'h0);
    set_cfg(3'b100, 1'b1, 1'b1);
    chk("R8", "dma on with data", 32'(dma_req), 32'h1);

    // R4 disable flushes and blocks reads/writes
    cnv_vld = 1'b1;
    set_cfg(3'b000, 1'b1, 1'b0);
    cnv_vld = 1'b1; rd_en = 1'b1;
    cyc();
    chk("R4", "flushed", 32'(st_empty), 32'h1);
    chk("R4", "ovf cleared", 32'(st_ovf), 32'h0);
    cnv_vld = 1'b1;
    cyc();
    set_cfg(3'b000, 1'b0, 1'b1);
    cyc();
    chk("R4", "empty after re-enable", 32'(st_level), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule